// File: doc/BRIEF.md
# Bit-Serial Pin Streamer

This block pushes bytes out of a general-purpose output port one bit at a time. Two bits of the port are set aside: one acts as a serial clock and one as serial data. This is the kind of stream used to load a configuration into a programmable logic device. The block owns the port's output register. Software can load that register directly while the streamer is idle. While a byte is streaming, only the pins selected as clock and data are touched.

Before streaming, software writes a 17-bit configuration word. It holds the clock pin mask, the data pin mask and a bit-order flag. The word is checked against two inputs: the changeable-pin mask and the output-enable mask of the eight lowest port bits. A word that fails the check is refused and the old setting stays. Each byte offered on the valid/ready input is sent as eight bit slots. In each slot the clock pins go low, then the data pins take the bit value, then the clock pins go high. Each of these three phases lasts `PHASE_CYC` clock cycles.

Top module: `serial_pin_streamer`

## Requirements
- R1: The configuration word carries the clock mask in bits [7:0], the data mask in bits [15:8] and the order flag in bit 16. The two masks act on port bits [7:0]. A word is accepted, with a one-cycle `cfg_ack` pulse on the cycle after the write, only if each mask shares at least one bit with `pin_chg` and at least one bit with `pin_oe`.
- R2: A word that fails the R1 check raises a one-cycle `cfg_err` on the cycle after the write. It leaves the previously accepted masks and order in force.
- R3: A configuration write made while a byte is streaming is refused with `cfg_err`, and the active setting does not change.
- R4: In each bit slot the port changes three times, PHASE_CYC cycles apart. First the clock-mask bits are cleared. Next the data-mask bits are set if the bit is 1 or cleared if it is 0. Last the clock-mask bits are set. The first change lands on the clock edge that accepts the byte.
- R5: With the order flag at 1 the byte goes out bit 7 first, down to bit 0. With the flag at 0 it goes out bit 0 first.
- R6: While a byte streams, port bits outside the clock and data masks keep their values.
- R7: `byte_ready` and `busy` are opposites. `busy` rises on the accepting edge and falls 24*PHASE_CYC cycles later, when the eighth high-clock phase ends.
- R8: A byte offered before any configuration has been accepted is consumed without changing the port. `wr_err` pulses for one cycle on the cycle after.
- R9: After reset, `port_out` is zero, `byte_ready` is 1, and `busy`, `cfg_ack`, `cfg_err` and `wr_err` are 0.
- R10: `out_we` loads `out_wdata` into the whole port register on the next edge when idle. It is ignored while a byte streams.
- R11: The data pins are held steady for at least one cycle before every rising transition of the clock pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_word | input | 17 | Order flag, data mask, clock mask |
| pin_chg | input | 8 | Pins software may change (bits [7:0]) |
| pin_oe | input | 8 | Pins currently enabled as outputs (bits [7:0]) |
| out_we | input | 1 | Direct load of the port register |
| out_wdata | input | PORT_W | Value for the direct load |
| byte_valid | input | 1 | Byte offered |
| byte_data | input | 8 | Byte to stream |
| byte_ready | output | 1 | Streamer idle, byte can be taken |
| busy | output | 1 | Byte streaming |
| cfg_ack | output | 1 | Configuration accepted (pulse) |
| cfg_err | output | 1 | Configuration refused (pulse) |
| wr_err | output | 1 | Byte refused, no configuration (pulse) |
| port_out | output | PORT_W | Output port register |

## Verification
`cfg_ack`, `cfg_err`, `wr_err` and a direct port load all show on the cycle after the strobe's edge. The bench drives each strobe for one edge and reads the result at the next falling edge. For a streamed byte, the port value in cycle c after the accepting edge belongs to bit slot c/(3*PHASE_CYC), phase (c mod 3*PHASE_CYC)/PHASE_CYC. The bench rebuilds that value from its own model at every falling edge of the 24*PHASE_CYC cycles. It then expects `byte_ready` back at the falling edge that follows.

// File: rtl/sps_pkg.sv
package sps_pkg;
  typedef enum logic [1:0] {
    PH_LOW  = 2'd0,
    PH_DATA = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

  // packed so that a cast of the 17-bit word lines up: [16] order, [15:8] data, [7:0] clock
  typedef struct packed {
    logic       msb_first;
    logic [7:0] dat;
    logic [7:0] clk;
  } wcfg_t;
endpackage

// File: rtl/sps_cfg_reg.sv
module sps_cfg_reg
  import sps_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [16:0] cfg_word,
  input  logic [7:0]  pin_chg,
  input  logic [7:0]  pin_oe,
  input  logic        busy,
  output wcfg_t       cfg_q,
  output logic        valid_q,
  output logic        ack_q,
  output logic        err_q
);
  wcfg_t req;
  logic  legal;
  logic  take;
  logic  ack_n;
  logic  err_n;

  always_comb begin
    req   = wcfg_t'(cfg_word);
    legal = (|(req.clk & pin_chg)) && (|(req.dat & pin_chg)) &&
            (|(req.clk & pin_oe))  && (|(req.dat & pin_oe))  && !busy;
    take  = cfg_we && legal;
    ack_n = take;
    err_n = cfg_we && !legal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      ack_q <= ack_n;
      err_q <= err_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      valid_q <= 1'b0;
    end else if (take) begin
      cfg_q   <= req;
      valid_q <= 1'b1;
    end
  end
endmodule

// File: rtl/sps_step_timer.sv
module sps_step_timer
  import sps_pkg::*;
#(
  parameter int PHASE_CYC = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  output logic   busy,
  output logic   enter,
  output phase_e nxt_phase,
  output logic [2:0] nxt_bit
);
  localparam int CW = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(PHASE_CYC - 1);

  logic          busy_q, busy_n;
  phase_e        ph_q, ph_n;
  logic [2:0]    bit_q, bit_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          adv;
  logic          last;

  always_comb begin
    adv    = busy_q && (cnt_q == CNT_LAST);
    last   = adv && (ph_q == PH_HIGH) && (bit_q == 3'd7);
    busy_n = busy_q;
    ph_n   = ph_q;
    bit_n  = bit_q;
    cnt_n  = cnt_q;
    enter  = 1'b0;
    if (start) begin
      busy_n = 1'b1;
      ph_n   = PH_LOW;
      bit_n  = 3'd0;
      cnt_n  = '0;
      enter  = 1'b1;
    end else if (busy_q) begin
      if (adv) begin
        cnt_n = '0;
        if (last) begin
          busy_n = 1'b0;
        end else begin
          enter = 1'b1;
          case (ph_q)
            PH_LOW:  ph_n = PH_DATA;
            PH_DATA: ph_n = PH_HIGH;
            default: begin
              ph_n  = PH_LOW;
              bit_n = bit_q + 3'd1;
            end
          endcase
        end
      end else begin
        cnt_n = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ph_q   <= PH_LOW;
      bit_q  <= 3'd0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_n;
      ph_q   <= ph_n;
      bit_q  <= bit_n;
      cnt_q  <= cnt_n;
    end
  end

  assign busy      = busy_q;
  assign nxt_phase = ph_n;
  assign nxt_bit   = bit_n;
endmodule

// File: rtl/sps_port_reg.sv
module sps_port_reg
  import sps_pkg::*;
#(
  parameter int PORT_W = 16,
  parameter logic [PORT_W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_we,
  input  logic [PORT_W-1:0] load_data,
  input  logic              busy,
  input  logic              enter,
  input  phase_e            phase,
  input  logic              bit_val,
  input  logic [PORT_W-1:0] clk_m,
  input  logic [PORT_W-1:0] dat_m,
  output logic [PORT_W-1:0] port_q
);
  logic [PORT_W-1:0] port_n;
  logic              port_en;

  always_comb begin
    port_n  = port_q;
    port_en = 1'b0;
    if (enter) begin
      port_en = 1'b1;
      case (phase)
        PH_LOW:  port_n = port_q & ~clk_m;
        PH_DATA: port_n = bit_val ? (port_q | dat_m) : (port_q & ~dat_m);
        default: port_n = port_q | clk_m;
      endcase
    end else if (load_we && !busy) begin
      port_en = 1'b1;
      port_n  = load_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_q <= RST_VAL;
    end else if (port_en) begin
      port_q <= port_n;
    end
  end
endmodule

// File: rtl/serial_pin_streamer.sv
module serial_pin_streamer
  import sps_pkg::*;
#(
  parameter int PORT_W    = 16,
  parameter int PHASE_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [16:0]       cfg_word,
  input  logic [7:0]        pin_chg,
  input  logic [7:0]        pin_oe,
  input  logic              out_we,
  input  logic [PORT_W-1:0] out_wdata,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  output logic              byte_ready,
  output logic              busy,
  output logic              cfg_ack,
  output logic              cfg_err,
  output logic              wr_err,
  output logic [PORT_W-1:0] port_out
);
  wcfg_t             cfg;
  logic              cfg_valid;
  logic [PORT_W-1:0] clk_m;
  logic [PORT_W-1:0] dat_m;
  logic              start;
  logic              refuse;
  logic              enter;
  phase_e            nxt_phase;
  logic [2:0]        nxt_bit;
  logic [7:0]        byte_q;
  logic              bit_val;
  logic              wr_err_q;

  sps_cfg_reg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_word (cfg_word),
    .pin_chg  (pin_chg),
    .pin_oe   (pin_oe),
    .busy     (busy),
    .cfg_q    (cfg),
    .valid_q  (cfg_valid),
    .ack_q    (cfg_ack),
    .err_q    (cfg_err)
  );

  always_comb begin
    clk_m   = PORT_W'(cfg.clk);
    dat_m   = PORT_W'(cfg.dat);
    start   = byte_valid && !busy && cfg_valid;
    refuse  = byte_valid && !busy && !cfg_valid;
    bit_val = cfg.msb_first ? byte_q[3'd7 - nxt_bit] : byte_q[nxt_bit];
  end

  sps_step_timer #(.PHASE_CYC(PHASE_CYC)) u_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .enter     (enter),
    .nxt_phase (nxt_phase),
    .nxt_bit   (nxt_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
    end else if (start) begin
      byte_q <= byte_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_err_q <= 1'b0;
    end else begin
      wr_err_q <= refuse;
    end
  end

  sps_port_reg #(.PORT_W(PORT_W)) u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_we   (out_we),
    .load_data (out_wdata),
    .busy      (busy),
    .enter     (enter),
    .phase     (nxt_phase),
    .bit_val   (bit_val),
    .clk_m     (clk_m),
    .dat_m     (dat_m),
    .port_q    (port_out)
  );

  assign byte_ready = !busy;
  assign wr_err     = wr_err_q;
endmodule

// File: rtl/sps_chk.sv
module sps_chk #(
  parameter int PORT_W    = 16,
  parameter int PHASE_CYC = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              byte_valid,
  input logic              byte_ready,
  input logic              cfg_err,
  input logic              wr_err,
  input logic              cfg_valid,
  input logic [PORT_W-1:0] clk_m,
  input logic [PORT_W-1:0] dat_m,
  input logic [PORT_W-1:0] port_out
);
  logic [15:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 16'd1;
    else busy_cnt <= '0;
  end

  // R7: streaming lasts exactly 24 phases
  p_busy_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busy_cnt == 16'(24 * PHASE_CYC));

  // R7: ready only drops on an offered byte
  p_ready_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(byte_ready) |-> $past(byte_valid));

  // R6: pins outside the masks hold while streaming
  p_outside_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ((port_out ^ $past(port_out)) & ~($past(clk_m) | $past(dat_m))) == '0);

  // R11: data steady before the clock rises
  p_data_setup_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (|(port_out & clk_m)) && !$past(|(port_out & clk_m)))
      |-> (port_out & dat_m & ~clk_m) == $past(port_out & dat_m & ~clk_m));

  // R2: a refused word keeps the old masks
  p_cfg_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (clk_m == $past(clk_m)) && (dat_m == $past(dat_m)));

  // R8: streaming only starts with a valid configuration
  p_start_cfg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cfg_valid));

  // R8: a refused byte never starts streaming
  p_err_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> !busy);
endmodule

bind serial_pin_streamer sps_chk #(.PORT_W(PORT_W), .PHASE_CYC(PHASE_CYC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .byte_valid (byte_valid),
  .byte_ready (byte_ready),
  .cfg_err    (cfg_err),
  .wr_err     (wr_err),
  .cfg_valid  (cfg_valid),
  .clk_m      (clk_m),
  .dat_m      (dat_m),
  .port_out   (port_out)
);

// File: tb/serial_pin_streamer_tb.sv
module serial_pin_streamer_tb;
  localparam int PW = 16;
  localparam int PH = 2;
  localparam int SLOT = 3 * PH;

  logic          clk;
  logic          rst_n;
  logic          cfg_we;
  logic [16:0]   cfg_word;
  logic [7:0]    pin_chg;
  logic [7:0]    pin_oe;
  logic          out_we;
  logic [PW-1:0] out_wdata;
  logic          byte_valid;
  logic [7:0]    byte_data;
  logic          byte_ready;
  logic          busy;
  logic          cfg_ack;
  logic          cfg_err;
  logic          wr_err;
  logic [PW-1:0] port_out;

  int errors = 0;
  int checks = 0;

  logic [PW-1:0] m_port;
  logic [7:0]    m_clk;
  logic [7:0]    m_dat;
  logic          m_msb;
  logic          m_valid;

  serial_pin_streamer #(.PORT_W(PW), .PHASE_CYC(PH)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_word(cfg_word),
    .pin_chg(pin_chg), .pin_oe(pin_oe), .out_we(out_we), .out_wdata(out_wdata),
    .byte_valid(byte_valid), .byte_data(byte_data), .byte_ready(byte_ready),
    .busy(busy), .cfg_ack(cfg_ack), .cfg_err(cfg_err), .wr_err(wr_err),
    .port_out(port_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic legal(input logic [16:0] w, input logic [7:0] chg, input logic [7:0] oe);
    return (|(w[7:0] & chg)) && (|(w[15:8] & chg)) && (|(w[7:0] & oe)) && (|(w[15:8] & oe));
  endfunction

  // port value after bit slot i, phase p (0 low, 1 data, 2 high)
  function automatic logic [PW-1:0] model_at(input logic [PW-1:0] base, input logic [7:0] b,
                                             input int i, input int p);
    logic [PW-1:0] v = base;
    logic [PW-1:0] cm = PW'(m_clk);
    logic [PW-1:0] dm = PW'(m_dat);
    for (int j = 0; j <= i; j++) begin
      logic bv = m_msb ? b[7-j] : b[j];
      for (int q = 0; q < 3; q++) begin
        if (j < i || q <= p) begin
          if (q == 0) v = v & ~cm;
          else if (q == 1) v = bv ? (v | dm) : (v & ~dm);
          else v = v | cm;
        end
      end
    end
    return v;
  endfunction

  task automatic do_cfg(input logic [16:0] w);
    logic ok = legal(w, pin_chg, pin_oe);
    @(negedge clk);
    cfg_we = 1'b1; cfg_word = w;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    @(negedge clk);
    chk("R1 cfg_ack", 32'(cfg_ack), 32'(ok));
    chk("R2 cfg_err", 32'(cfg_err), 32'(!ok));
    if (ok) begin
      m_clk = w[7:0]; m_dat = w[15:8]; m_msb = w[16]; m_valid = 1'b1;
    end
  endtask

  task automatic sw_load(input logic [PW-1:0] v);
    @(negedge clk);
    out_we = 1'b1; out_wdata = v;
    @(posedge clk); #1;
    out_we = 1'b0;
    @(negedge clk);
    chk("R10 direct load", 32'(port_out), 32'(v));
    m_port = v;
  endtask

  // mode 0 plain, 1 direct write mid-byte, 2 configuration write mid-byte
  task automatic send(input logic [7:0] b, input int mode);
    logic [PW-1:0] fin;
    @(negedge clk);
    chk("R7 ready before byte", 32'(byte_ready), 32'd1);
    byte_valid = 1'b1; byte_data = b;
    @(posedge clk); #1;
    byte_valid = 1'b0;
    for (int c = 0; c < 24 * PH; c++) begin
      @(negedge clk);
      if (c == 8) begin
        if (mode == 2) begin
          chk("R3 cfg_err while busy", 32'(cfg_err), 32'd1);
          chk("R3 cfg_ack while busy", 32'(cfg_ack), 32'd0);
        end
        out_we = 1'b0; cfg_we = 1'b0;
      end
      chk(m_msb ? "R4 R5 msb waveform" : "R4 R5 lsb waveform",
          32'(port_out), 32'(model_at(m_port, b, c / SLOT, (c % SLOT) / PH)));
      chk("R7 ready low", 32'(byte_ready), 32'd0);
      if (c == 7 && mode == 1) begin
        out_we = 1'b1; out_wdata = PW'($urandom);
      end
      if (c == 7 && mode == 2) begin
        cfg_we = 1'b1;
        cfg_word = {~m_msb, m_clk, m_dat};
      end
    end
    @(negedge clk);
    fin = model_at(m_port, b, 7, 2);
    chk("R7 ready after 24 phases", 32'(byte_ready), 32'd1);
    chk("R6 final port", 32'(port_out), 32'(fin));
    m_port = fin;
  endtask

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; cfg_we = 1'b0; cfg_word = '0; pin_chg = '0; pin_oe = '0;
    out_we = 1'b0; out_wdata = '0; byte_valid = 1'b0; byte_data = '0;
    m_port = '0; m_clk = '0; m_dat = '0; m_msb = 1'b0; m_valid = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R9 port reset", 32'(port_out), 32'd0);
    chk("R9 ready reset", 32'(byte_ready), 32'd1);
    chk("R9 busy reset", 32'(busy), 32'd0);
    chk("R9 flags reset", {29'd0, cfg_ack, cfg_err, wr_err}, 32'd0);

    // R8: byte with no configuration
    sw_load(16'h5A3C);
    byte_valid = 1'b1; byte_data = 8'hFF;
    @(posedge clk); #1;
    byte_valid = 1'b0;
    @(negedge clk);
    chk("R8 wr_err", 32'(wr_err), 32'd1);
    chk("R8 port unchanged", 32'(port_out), 32'(m_port));
    chk("R8 ready", 32'(byte_ready), 32'd1);
    @(negedge clk);
    chk("R8 wr_err pulse", 32'(wr_err), 32'd0);

    // R1/R2: legality against changeable and output-enable masks
    pin_chg = 8'hFF; pin_oe = 8'hF0;
    do_cfg({1'b1, 8'h02, 8'h01});   // pins not outputs: refused
    do_cfg({1'b1, 8'h20, 8'h10});   // accepted, msb first
    do_cfg({1'b0, 8'h00, 8'h40});   // empty data mask: refused
    pin_chg = 8'h0F;
    do_cfg({1'b0, 8'h80, 8'h40});   // outputs but not changeable: refused
    pin_chg = 8'hFF;
    send(8'hB4, 0);                  // runs on the kept msb setting
    sw_load(16'hA5C3);
    send(8'h01, 0);
    do_cfg({1'b0, 8'h80, 8'h40});   // lsb first
    send(8'hB4, 0);
    send(8'h00, 1);                  // R10: direct write mid-byte ignored
    send(8'hFF, 2);                  // R3: configuration mid-byte refused
    send(8'h6D, 0);

    // random mix
    for (int n = 0; n < 14; n++) begin
      logic [16:0] w;
      pin_chg = 8'($urandom) | 8'h11;
      pin_oe  = 8'($urandom) | 8'h22;
      w = {1'($urandom), 8'(1 << ($urandom % 8)), 8'(1 << ($urandom % 8))};
      if (n % 4 == 3) w[15:8] = 8'($urandom);
      do_cfg(w);
      if (n % 3 == 0) sw_load(PW'($urandom));
      if (m_valid) send(8'($urandom), (n % 5 == 4) ? 1 : 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule